// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Engine

This block is one transmit DMA channel. It reads a table of 8-byte buffer descriptors from system memory and streams the bytes of each described buffer to a low-speed peripheral over a byte-wide valid/ready link. Software builds the table at `tbl_base` and marks each entry it hands over with the full flag. It then starts the channel by raising `chan_en`. The engine fetches descriptor 0 and checks the full flag. It reads the buffer in bursts of at most 16 bytes and forwards every byte. It then writes the descriptor's flag byte back with full cleared, which returns the entry to software, and moves on.

A packet ends with the descriptor that carries the last flag. The interrupt flag on a descriptor raises a sticky interrupt when that descriptor completes. The wrap flag sends the next fetch back to the start of the table. If a fetched descriptor is not full, the engine stops and reports a fault. Whether it ends by completing a packet or by a fault, the channel parks. It starts again only when `chan_en` is taken low and then high again, and each start begins at index 0.

Descriptor layout in memory, little-endian: bytes 0-3 hold the buffer pointer, bytes 4-5 the byte length, and byte 6 the flags (bit 0 full, bit 1 last, bit 2 interrupt, bit 3 wrap). Byte 7 is ignored.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `busy`, `irq`, `desc_fault`, `mem_req`, `tx_valid` and `mem_we` are all 0.
- R2: A 0-to-1 change of `chan_en` while parked starts a fetch of descriptor index 0: an 8-byte read at `tbl_base`, with pointer in bytes 0-3, length in bytes 4-5 and flags in byte 6 (bit 0 full, bit 1 last, bit 2 interrupt, bit 3 wrap).
- R3: A fetched descriptor whose full bit is 0 causes no data read and no writeback. It sets `desc_fault`, and the engine parks. `desc_fault` is cleared on the next start.
- R4: Buffer data is read in bursts of at most 16 bytes at consecutive addresses. Only the final burst of a buffer may be shorter. A request holds its address and length stable until `mem_gnt`.
- R5: Every buffer byte is delivered on `tx_data` exactly once and in address order. A byte is taken from memory only in a cycle where the peripheral accepts it.
- R6: After a buffer is sent, a one-byte write to descriptor address + 6 stores the flag byte with bit 0 cleared and the other flags unchanged.
- R7: Descriptors are processed at ascending indices (8-byte stride) until the one with the last flag completes. No later descriptor is fetched.
- R8: After a descriptor with the wrap flag completes (and the last flag is clear), the next fetch address is `tbl_base`.
- R9: `irq` is set when a descriptor with the interrupt flag completes and stays set until an `irq_clr` pulse. If both happen in the same cycle, the set wins.
- R10: Once parked, the engine makes no memory request while `chan_en` stays high. Only a 0-then-1 sequence on `chan_en` restarts it, and the restart is at index 0.
- R11: A descriptor of length 0 causes no data read but is still written back with full cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable level; a rising edge while parked starts a run |
| tbl_base | input | AW | Byte address of descriptor 0 |
| irq_clr | input | 1 | Pulse that clears `irq` |
| irq | output | 1 | Sticky interrupt |
| desc_fault | output | 1 | Set when a fetched descriptor was not full |
| busy | output | 1 | Engine is not parked |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | Burst start byte address |
| mem_len | output | BLW | Burst length in bytes (1 to 16) |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read byte valid |
| mem_rdata | input | 8 | Read byte |
| mem_rready | output | 1 | Engine takes the read byte |
| mem_we | output | 1 | Descriptor flag byte write strobe |
| mem_waddr | output | AW | Write byte address |
| mem_wdata | output | 8 | Write byte |
| tx_valid | output | 1 | Byte for the peripheral is valid |
| tx_data | output | 8 | Byte for the peripheral |
| tx_ready | input | 1 | Peripheral accepts the byte |

## Verification
The transfer path is tried with four packet shapes. Buffer lengths of 18, 24 and 100 separate correct partial-burst sizing from full-burst rounding. An exactly 16-byte buffer followed by a zero-length one exposes off-by-one burst counts and a zero length that is wrongly read. A two-entry table whose second entry wraps shows whether the fetch returns to the base and then stops on the entry that was already returned to software. Memory stalls and peripheral back-pressure are pseudo-random in most runs and absent in one, so the byte order and count are checked both with and without flow control.

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
  parameter int AW    = 32,
  parameter int IDXW  = 8,
  parameter int BURST = 16,
  localparam int BLW  = $clog2(BURST) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chan_en,
  input  logic [AW-1:0]  tbl_base,
  input  logic           irq_clr,
  output logic           irq,
  output logic           desc_fault,
  output logic           busy,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic [BLW-1:0] mem_len,
  input  logic           mem_gnt,
  input  logic           mem_rvalid,
  input  logic [7:0]     mem_rdata,
  output logic           mem_rready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_waddr,
  output logic [7:0]     mem_wdata,
  output logic           tx_valid,
  output logic [7:0]     tx_data,
  input  logic           tx_ready
);

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DRD, S_CHK, S_BREQ, S_BDAT, S_WB} st_t;

  st_t             st;
  logic            en_q;
  logic [IDXW-1:0] idx;
  logic [55:0]     dbuf;
  logic [AW-1:0]   ptr;
  logic [15:0]     left;
  logic [BLW-1:0]  blen, cnt;

  wire [AW-1:0]  daddr = tbl_base + AW'({idx, 3'b000});
  wire           fl_f  = dbuf[48];
  wire           fl_l  = dbuf[49];
  wire           fl_i  = dbuf[50];
  wire           fl_w  = dbuf[51];
  wire [15:0]    dlen  = dbuf[47:32];
  wire [BLW-1:0] bnext = (left >= 16'(BURST)) ? BLW'(BURST) : BLW'(left);
  wire           rd_hs = mem_rvalid & mem_rready;

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_DREQ) || (st == S_BREQ);
  assign mem_addr   = (st == S_DREQ) ? daddr : ptr;
  assign mem_len    = (st == S_DREQ) ? BLW'(8) : bnext;
  assign mem_rready = (st == S_DRD) || ((st == S_BDAT) && tx_ready);
  assign tx_valid   = (st == S_BDAT) && mem_rvalid;
  assign tx_data    = mem_rdata;
  assign mem_we     = (st == S_WB);
  assign mem_waddr  = daddr + AW'(6);
  assign mem_wdata  = {dbuf[55:49], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      en_q       <= 1'b0;
      idx        <= '0;
      dbuf       <= '0;
      ptr        <= '0;
      left       <= '0;
      blen       <= '0;
      cnt        <= '0;
      irq        <= 1'b0;
      desc_fault <= 1'b0;
    end else begin
      en_q <= chan_en;
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE: if (chan_en && !en_q) begin
          idx        <= '0;
          desc_fault <= 1'b0;
          st         <= S_DREQ;
        end
        S_DREQ: if (mem_gnt) begin
          cnt <= '0;
          st  <= S_DRD;
        end
        S_DRD: if (mem_rvalid) begin
          if (cnt != BLW'(7)) dbuf <= {mem_rdata, dbuf[55:8]};
          cnt <= cnt + 1'b1;
          if (cnt == BLW'(7)) st <= S_CHK;
        end
        S_CHK: begin
          if (!fl_f) begin
            desc_fault <= 1'b1;
            st         <= S_IDLE;
          end else begin
            ptr  <= AW'(dbuf[31:0]);
            left <= dlen;
            st   <= (dlen == '0) ? S_WB : S_BREQ;
          end
        end
        S_BREQ: if (mem_gnt) begin
          blen <= bnext;
          cnt  <= '0;
          st   <= S_BDAT;
        end
        S_BDAT: if (rd_hs) begin
          ptr  <= ptr + 1'b1;
          left <= left - 1'b1;
          cnt  <= cnt + 1'b1;
          if (cnt == blen - 1'b1) st <= (left == 16'd1) ? S_WB : S_BREQ;
        end
        S_WB: begin
          if (fl_i) irq <= 1'b1;
          if (fl_l) st <= S_IDLE;
          else begin
            idx <= fl_w ? '0 : idx + 1'b1;
            st  <= S_DREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
  parameter int AW    = 32,
  parameter int BURST = 16,
  parameter int BLW   = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           chan_en,
  input logic           irq_clr,
  input logic           irq,
  input logic           desc_fault,
  input logic           busy,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic [BLW-1:0] mem_len,
  input logic           mem_gnt,
  input logic           mem_rready,
  input logic           mem_we,
  input logic [7:0]     mem_wdata,
  input logic           tx_valid,
  input logic           tx_ready
);

  logic en_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= chan_en;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R4
  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= BLW'(BURST))); // R4
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |-> !mem_rready); // R5
  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[0]); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !mem_we |=> !irq); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R9
  AST_FAULT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_fault |-> !busy); // R3
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(chan_en && !en_prev) |=> !busy); // R10

endmodule

bind txdesc_dma txdesc_dma_chk #(.AW(AW), .BURST(BURST), .BLW(BLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .irq_clr(irq_clr), .irq(irq),
  .desc_fault(desc_fault), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rready(mem_rready), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/test_txdesc_dma.sv
module test_txdesc_dma;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, chan_en, irq_clr, irq, desc_fault, busy;
  logic [31:0] tbl_base;
  logic        mem_req, mem_gnt, mem_rvalid, mem_rready, mem_we;
  logic [31:0] mem_addr, mem_waddr;
  logic [4:0]  mem_len;
  logic [7:0]  mem_rdata, mem_wdata, tx_data;
  logic        tx_valid, tx_ready;

  txdesc_dma i_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tbl_base(tbl_base), .irq_clr(irq_clr),
    .irq(irq), .desc_fault(desc_fault), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rready(mem_rready), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  logic [7:0]  mem [0:4095];
  logic [7:0]  rx  [0:255];
  logic [31:0] rq_addr [0:63];
  logic [4:0]  rq_len  [0:63];
  int          nrx, nreq;
  logic        log_clr, fast;
  logic [15:0] lfsr;
  logic        mgo, mbusy;
  logic [11:0] maddr;
  logic [4:0]  mleft;
  int          checks = 0, errors = 0;

  assign mem_rvalid = mbusy && mgo;
  assign mem_rdata  = mem[maddr];
  assign tx_ready   = fast ? 1'b1 : (lfsr[5] | lfsr[9]);

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy <= 1'b0; mem_gnt <= 1'b0; mgo <= 1'b0; lfsr <= 16'hACE1;
      maddr <= '0; mleft <= '0; nrx <= 0; nreq <= 0;
    end else begin
      mem_gnt <= 1'b0;
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mgo     <= fast | lfsr[1] | lfsr[4];
      if (!mbusy && mem_req && !mem_gnt) begin
        mem_gnt <= 1'b1; maddr <= mem_addr[11:0]; mleft <= mem_len; mbusy <= 1'b1;
        if (nreq < 64) begin rq_addr[nreq] <= mem_addr; rq_len[nreq] <= mem_len; end
        nreq <= nreq + 1;
      end
      if (mem_rvalid && mem_rready) begin
        maddr <= maddr + 1'b1; mleft <= mleft - 1'b1;
        if (mleft == 5'd1) mbusy <= 1'b0;
      end
      if (tx_valid && tx_ready) begin
        if (nrx < 256) rx[nrx] <= tx_data;
        nrx <= nrx + 1;
      end
      if (mem_we) mem[mem_waddr[11:0]] <= mem_wdata;
      if (log_clr) begin nrx <= 0; nreq <= 0; end
    end
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input int i, input int ptr, input int len, input logic [7:0] fl);
    int a = base + i * 8;
    for (int b = 0; b < 4; b++) mem[a + b] = 8'(ptr >> (8 * b));
    mem[a + 4] = 8'(len);
    mem[a + 5] = 8'(len >> 8);
    mem[a + 6] = fl;
    mem[a + 7] = 8'hEE;
  endtask

  task automatic chk_stream(input int k0, input int ptr, input int len, input string r);
    int bad = 0;
    for (int i = 0; i < len; i++) if (rx[k0 + i] !== pat(ptr + i)) bad++;
    chk(bad == 0, r, bad, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic run(input int base);
    int t = 0;
    @(negedge clk); tbl_base = base; chan_en = 1'b0; log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    @(negedge clk); chan_en = 1'b1;
    while (!busy && t < 20) begin @(negedge clk); t++; end
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(!busy, "R10 run did not park", busy, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !irq && !desc_fault, "R1 status after reset", {busy, irq, desc_fault}, 0);
    chk(!mem_req && !tx_valid && !mem_we, "R1 strobes after reset", {mem_req, tx_valid, mem_we}, 0);
  endtask

  task automatic t_packet();
    fast = 1'b0;
    put_desc(0, 0, 32'h200, 18,  8'h01);
    put_desc(0, 1, 32'h300, 24,  8'h01);
    put_desc(0, 2, 32'h400, 100, 8'h07);
    put_desc(0, 3, 32'h600, 4,   8'h03);
    run(0);
    chk(rq_addr[0] == 0 && rq_len[0] == 8, "R2 first fetch", rq_addr[0], 0);
    chk(nrx == 142, "R5 R7 byte count", nrx, 142);
    chk_stream(0, 32'h200, 18, "R5 buffer 0 bytes");
    chk_stream(18, 32'h300, 24, "R5 buffer 1 bytes");
    chk_stream(42, 32'h400, 100, "R5 buffer 2 bytes");
    chk(nreq == 14, "R4 request count", nreq, 14);
    chk(rq_addr[1] == 32'h200 && rq_len[1] == 16, "R4 full burst", rq_len[1], 16);
    chk(rq_addr[2] == 32'h210 && rq_len[2] == 2, "R4 partial burst", rq_len[2], 2);
    chk(rq_addr[3] == 8 && rq_len[3] == 8, "R7 second fetch", rq_addr[3], 8);
    chk(mem[6] == 8'h00 && mem[14] == 8'h00, "R6 writeback 0/1", {mem[6], mem[14]}, 0);
    chk(mem[22] == 8'h06, "R6 writeback keeps flags", mem[22], 6);
    chk(mem[30] == 8'h03, "R7 later descriptor untouched", mem[30], 3);
    chk(irq && !desc_fault, "R9 irq after last", {irq, desc_fault}, 2);
  endtask

  task automatic t_park();
    int n0 = nreq;
    repeat (40) @(negedge clk);
    chk(!busy && nreq == n0, "R10 parked with enable high", nreq, n0);
    pulse_clr();
    chk(!irq, "R9 irq clear", irq, 0);
    run(0);
    chk(desc_fault && nrx == 0, "R3 restart hits released entry", {desc_fault, 8'(nrx)}, 256);
    chk(nreq == 1 && rq_addr[0] == 0, "R10 restart at index 0", rq_addr[0], 0);
    chk(mem[6] == 8'h00 && !irq, "R3 no writeback on fault", mem[6], 0);
  endtask

  task automatic t_wrap();
    fast = 1'b1;
    put_desc(32'h80, 0, 32'h500, 5, 8'h01);
    put_desc(32'h80, 1, 32'h540, 3, 8'h09);
    put_desc(32'h80, 2, 32'h580, 4, 8'h03);
    run(32'h80);
    chk(nrx == 8, "R8 bytes before wrap", nrx, 8);
    chk_stream(0, 32'h500, 5, "R5 wrap buffer 0");
    chk_stream(5, 32'h540, 3, "R5 wrap buffer 1");
    chk(nreq == 5 && rq_addr[4] == 32'h80 && rq_len[4] == 8, "R8 fetch returns to base", rq_addr[4], 32'h80);
    chk(desc_fault, "R3 fault after wrap", desc_fault, 1);
    chk(mem[32'h80 + 14] == 8'h08, "R6 wrap flag kept", mem[32'h80 + 14], 8);
    chk(mem[32'h80 + 22] == 8'h03, "R7 entry past wrap untouched", mem[32'h80 + 22], 3);
    chk(!irq, "R9 no irq without flag", irq, 0);
  endtask

  task automatic t_zero();
    fast = 1'b0;
    pulse_clr();
    put_desc(32'hC0, 0, 32'h700, 16, 8'h05);
    put_desc(32'hC0, 1, 32'h800, 0,  8'h01);
    put_desc(32'hC0, 2, 32'h900, 17, 8'h03);
    run(32'hC0);
    chk(nrx == 33, "R11 byte count", nrx, 33);
    chk_stream(0, 32'h700, 16, "R5 exact burst bytes");
    chk_stream(16, 32'h900, 17, "R5 bytes after empty entry");
    chk(nreq == 6, "R11 no read for empty entry", nreq, 6);
    chk(rq_len[1] == 16 && rq_addr[2] == 32'hC8, "R4 one burst for 16 bytes", rq_len[1], 16);
    chk(mem[32'hC0 + 14] == 8'h00, "R11 empty entry released", mem[32'hC0 + 14], 0);
    chk(irq && !desc_fault, "R9 irq from middle entry", {irq, desc_fault}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; irq_clr = 1'b0; tbl_base = '0; log_clr = 1'b0; fast = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_packet();
    t_park();
    t_wrap();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule